// File: doc/BRIEF.md
# Dual-Window Host Address Decoder

This block sits between a host bus and the register file of a peripheral and decides, for every host address, whether the peripheral is being addressed. It offers two windows. A 16-byte I/O window is always decoded. A 4 KB memory window decodes only once software or configuration has turned it on. For a hit it reports which window matched and the register offset inside that window.

The base of each window sits in a register. After reset the I/O base is 0x300 and the memory window is off. A loader that reads a serial configuration memory then presents decoded words together with a valid flag, and closes the load with an end pulse that says whether the whole image was good. Only a good image replaces the defaults. While the load is in progress no hit is reported. Later, software can move the memory window and switch it on by writing two registers inside the I/O window.

Top module: `windec_top`

## Requirements
- R1: After reset the I/O base is 0x300 and the memory window is disabled. io_hit and mem_hit stay 0 until the first cfg_end pulse.
- R2: io_hit is 1 when host_addr[19:4] equals the I/O page, whatever the memory-window setting. reg_off then equals host_addr[3:0], zero-extended.
- R3: mem_hit is 1 only when the memory page is nonzero, the enable bit is 1 and host_addr[19:12] equals the memory page. reg_off then equals host_addr[11:0].
- R4: During the load, a word with cfg_vld=1 is staged according to cfg_idx. Index 0 is the I/O page (cfg_data[15:0] = base>>4). Index 1 is the memory page (cfg_data[7:0] = base>>12). Index 2 is control, where bit 0 is the memory enable. A cfg_end pulse with cfg_good=1 commits the staged values.
- R5: A cfg_end pulse with cfg_good=0 ends the load and leaves all reset defaults in place.
- R6: A write (host_wr=1) that hits the I/O window takes effect at the next clock edge. Offset 0x8 loads the memory page from host_wdata[7:0]. Offset 0x9 loads the enable from host_wdata[0].
- R7: If an address matches both windows, only io_hit is reported, with the I/O offset, and conflict is 1. Otherwise conflict is 0.
- R8: Configuration words and end pulses that arrive after the load has ended are ignored.
- R9: A write to any other I/O offset, or a write that does not hit the I/O window, leaves both base registers and the enable unchanged.
- R10: When neither window hits, reg_off is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vld | input | 1 | Configuration word valid |
| cfg_idx | input | 2 | Configuration word index |
| cfg_data | input | 16 | Configuration word |
| cfg_end | input | 1 | Load-complete pulse |
| cfg_good | input | 1 | Image valid, sampled with cfg_end |
| host_addr | input | 20 | Host address |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 8 | Host write data |
| io_hit | output | 1 | Address falls in the I/O window |
| mem_hit | output | 1 | Address falls in the memory window |
| conflict | output | 1 | Both windows match this address |
| reg_off | output | 12 | Offset inside the hit window |

## Verification
A wrong base or enable register does not show until the host presents an address. At that point the error shows in the same cycle as a missing, extra or misplaced hit. The bench therefore probes each window edge, and just outside it, right after every load and every write. A stuck load phase shows as hits that never appear after the end pulse. An end pulse taken too early shows as hits during the load.

// File: rtl/windec_pkg.sv
package windec_pkg;

    // Index of a configuration word presented by the loader
    typedef enum logic [1:0] {
        CFG_IO_PAGE  = 2'd0,
        CFG_MEM_PAGE = 2'd1,
        CFG_CTRL     = 2'd2
    } cfg_idx_e;

    // Register offsets inside the I/O window that software may write
    localparam logic [3:0] REG_MEM_PAGE = 4'h8;
    localparam logic [3:0] REG_CTRL     = 4'h9;

endpackage

// File: rtl/windec_match.sv
module windec_match #(
    parameter int ADDR_W = 20,
    parameter int SPAN_W = 4,
    localparam int PG_W  = ADDR_W - SPAN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PG_W-1:0]   page,
    input  logic              enable,
    output logic              match,
    output logic [SPAN_W-1:0] offset
);

    assign match  = enable && (addr[ADDR_W-1:SPAN_W] == page);
    assign offset = addr[SPAN_W-1:0];

endmodule

// File: rtl/windec_cfg_stage.sv
module windec_cfg_stage
    import windec_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int IO_PG_W  = 16,
    parameter int MEM_PG_W = 8,
    parameter logic [IO_PG_W-1:0]  IO_PG_RST  = '0,
    parameter logic [MEM_PG_W-1:0] MEM_PG_RST = '0,
    parameter logic                MEM_EN_RST = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_vld,
    input  logic [1:0]          cfg_idx,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                cfg_end,
    input  logic                cfg_good,
    output logic                loading,
    output logic                commit,
    output logic [IO_PG_W-1:0]  stg_io_pg,
    output logic [MEM_PG_W-1:0] stg_mem_pg,
    output logic                stg_mem_en
);

    typedef struct packed {
        logic                loading;
        logic [IO_PG_W-1:0]  io_pg;
        logic [MEM_PG_W-1:0] mem_pg;
        logic                mem_en;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (stage_q.loading) begin
            if (cfg_end) begin
                stage_d.loading = 1'b0;
            end else if (cfg_vld) begin
                case (cfg_idx)
                    CFG_IO_PAGE:  stage_d.io_pg  = IO_PG_W'(cfg_data);
                    CFG_MEM_PAGE: stage_d.mem_pg = MEM_PG_W'(cfg_data);
                    CFG_CTRL:     stage_d.mem_en = cfg_data[0];
                    default:      stage_d        = stage_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q.loading <= 1'b1;
            stage_q.io_pg   <= IO_PG_RST;
            stage_q.mem_pg  <= MEM_PG_RST;
            stage_q.mem_en  <= MEM_EN_RST;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign loading    = stage_q.loading;
    assign commit     = stage_q.loading && cfg_end && cfg_good;
    assign stg_io_pg  = stage_q.io_pg;
    assign stg_mem_pg = stage_q.mem_pg;
    assign stg_mem_en = stage_q.mem_en;

    AST_LOAD_ENDS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_q.loading |=> !stage_q.loading);                               // R8

    AST_END_CLOSES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_end |=> !stage_q.loading);                                        // R5

endmodule

// File: rtl/windec_top.sv
module windec_top
    import windec_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int IO_SPAN_W   = 4,
    parameter int MEM_SPAN_W  = 12,
    parameter int CFG_W       = 16,
    parameter int IO_BASE_RST = 'h300,
    localparam int IO_PG_W    = ADDR_W - IO_SPAN_W,
    localparam int MEM_PG_W   = ADDR_W - MEM_SPAN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_vld,
    input  logic [1:0]            cfg_idx,
    input  logic [CFG_W-1:0]      cfg_data,
    input  logic                  cfg_end,
    input  logic                  cfg_good,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_wr,
    input  logic [MEM_PG_W-1:0]   host_wdata,
    output logic                  io_hit,
    output logic                  mem_hit,
    output logic                  conflict,
    output logic [MEM_SPAN_W-1:0] reg_off
);

    localparam logic [IO_PG_W-1:0] IO_PG_RST = IO_PG_W'(IO_BASE_RST >> IO_SPAN_W);

    typedef struct packed {
        logic [IO_PG_W-1:0]  io_pg;
        logic [MEM_PG_W-1:0] mem_pg;
        logic                mem_en;
    } bases_t;

    bases_t bases_d, bases_q;

    logic                  loading, commit;
    logic [IO_PG_W-1:0]    stg_io_pg;
    logic [MEM_PG_W-1:0]   stg_mem_pg;
    logic                  stg_mem_en;
    logic                  io_m, mem_m, mem_live, wr_ok;
    logic [IO_SPAN_W-1:0]  io_off;
    logic [MEM_SPAN_W-1:0] mem_off;

    windec_cfg_stage #(
        .CFG_W     (CFG_W),
        .IO_PG_W   (IO_PG_W),
        .MEM_PG_W  (MEM_PG_W),
        .IO_PG_RST (IO_PG_RST),
        .MEM_PG_RST('0),
        .MEM_EN_RST(1'b0)
    ) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_vld   (cfg_vld),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .cfg_end   (cfg_end),
        .cfg_good  (cfg_good),
        .loading   (loading),
        .commit    (commit),
        .stg_io_pg (stg_io_pg),
        .stg_mem_pg(stg_mem_pg),
        .stg_mem_en(stg_mem_en)
    );

    windec_match #(.ADDR_W(ADDR_W), .SPAN_W(IO_SPAN_W)) i_io_match (
        .addr  (host_addr),
        .page  (bases_q.io_pg),
        .enable(1'b1),
        .match (io_m),
        .offset(io_off)
    );

    assign mem_live = bases_q.mem_en && (bases_q.mem_pg != '0);

    windec_match #(.ADDR_W(ADDR_W), .SPAN_W(MEM_SPAN_W)) i_mem_match (
        .addr  (host_addr),
        .page  (bases_q.mem_pg),
        .enable(mem_live),
        .match (mem_m),
        .offset(mem_off)
    );

    // Window outputs: I/O has priority, nothing during the load
    always_comb begin
        io_hit   = !loading && io_m;
        mem_hit  = !loading && mem_m && !io_m;
        conflict = !loading && io_m && mem_m;
        if (io_hit)       reg_off = MEM_SPAN_W'(io_off);
        else if (mem_hit) reg_off = mem_off;
        else              reg_off = '0;
    end

    assign wr_ok = io_hit && host_wr;

    always_comb begin
        bases_d = bases_q;
        if (commit) begin
            bases_d.io_pg  = stg_io_pg;
            bases_d.mem_pg = stg_mem_pg;
            bases_d.mem_en = stg_mem_en;
        end else if (wr_ok) begin
            if (io_off == IO_SPAN_W'(REG_MEM_PAGE)) bases_d.mem_pg = host_wdata;
            if (io_off == IO_SPAN_W'(REG_CTRL))     bases_d.mem_en = host_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bases_q.io_pg  <= IO_PG_RST;
            bases_q.mem_pg <= '0;
            bases_q.mem_en <= 1'b0;
        end else begin
            bases_q <= bases_d;
        end
    end

    AST_QUIET_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !io_hit && !mem_hit);                                     // R1

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_hit, mem_hit}));                                         // R7

    AST_CONFLICT_IO: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> io_hit && reg_off == MEM_SPAN_W'(host_addr[IO_SPAN_W-1:0])); // R7

    AST_MEM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> bases_q.mem_en && bases_q.mem_pg != '0);                  // R3

    AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && io_off == IO_SPAN_W'(REG_MEM_PAGE))
        |=> bases_q.mem_pg == $past(host_wdata));                             // R6

    AST_BASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !commit) |=> $stable(bases_q));                            // R9

    AST_IDLE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_hit && !mem_hit) |-> reg_off == '0);                             // R10

endmodule

// File: tb/test_windec_top.sv
module test_windec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_vld = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic        cfg_end = 1'b0;
    logic        cfg_good = 1'b0;
    logic [19:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        io_hit, mem_hit, conflict;
    logic [11:0] reg_off;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    windec_top i_windec_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_vld(cfg_vld), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .cfg_end(cfg_end), .cfg_good(cfg_good),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .io_hit(io_hit), .mem_hit(mem_hit), .conflict(conflict), .reg_off(reg_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive an address and check the combinational decode
    task automatic probe(input string req, input logic [19:0] a,
                         input logic e_io, input logic e_mem,
                         input logic e_cf, input logic [11:0] e_off);
        @(negedge clk);
        host_addr = a;
        #1;
        chk({req, " io_hit"},   32'(io_hit),   32'(e_io));
        chk({req, " mem_hit"},  32'(mem_hit),  32'(e_mem));
        chk({req, " conflict"}, 32'(conflict), 32'(e_cf));
        chk({req, " reg_off"},  32'(reg_off),  32'(e_off));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_vld = 1'b0; cfg_end = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [1:0] idx, input logic [15:0] d);
        @(negedge clk);
        cfg_vld = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_vld = 1'b0;
    endtask

    task automatic send_end(input logic good);
        @(negedge clk);
        cfg_end = 1'b1; cfg_good = good;
        @(negedge clk);
        cfg_end = 1'b0;
    endtask

    task automatic host_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset_defaults();
        do_reset();
        probe("R1 loading io", 20'h00300, 0, 0, 0, 12'h000);
        send_end(1'b0);
        probe("R1 default base", 20'h00300, 1, 0, 0, 12'h000);
        probe("R2 top of io window", 20'h0030F, 1, 0, 0, 12'h00F);
        probe("R10 above io window", 20'h00310, 0, 0, 0, 12'h000);
        probe("R10 below io window", 20'h002FF, 0, 0, 0, 12'h000);
        probe("R1 mem window off", 20'h00005, 0, 0, 0, 12'h000);
    endtask

    task automatic t_cfg_good();
        do_reset();
        send_word(2'd0, 16'h0280);
        send_word(2'd1, 16'h00C8);
        send_word(2'd2, 16'h0001);
        probe("R1 still loading", 20'h02803, 0, 0, 0, 12'h000);
        send_end(1'b1);
        probe("R4 new io base", 20'h02803, 1, 0, 0, 12'h003);
        probe("R4 old io base gone", 20'h00300, 0, 0, 0, 12'h000);
        probe("R4 mem window", 20'hC8ABC, 0, 1, 0, 12'hABC);
        probe("R3 mem window end", 20'hC9000, 0, 0, 0, 12'h000);
    endtask

    task automatic t_late_cfg();
        send_word(2'd0, 16'h0400);
        send_word(2'd2, 16'h0000);
        send_end(1'b1);
        probe("R8 io base kept", 20'h02803, 1, 0, 0, 12'h003);
        probe("R8 late base unused", 20'h04000, 0, 0, 0, 12'h000);
        probe("R8 mem still on", 20'hC8001, 0, 1, 0, 12'h001);
    endtask

    task automatic t_cfg_bad();
        do_reset();
        send_word(2'd0, 16'h0280);
        send_word(2'd1, 16'h00C8);
        send_word(2'd2, 16'h0001);
        send_end(1'b0);
        probe("R5 default io kept", 20'h00307, 1, 0, 0, 12'h007);
        probe("R5 staged io unused", 20'h02803, 0, 0, 0, 12'h000);
        probe("R5 mem stays off", 20'hC8000, 0, 0, 0, 12'h000);
    endtask

    task automatic t_sw_write();
        do_reset();
        send_end(1'b0);
        host_write(20'h00309, 8'h01);
        probe("R3 zero page no hit", 20'h00123, 0, 0, 0, 12'h000);
        host_write(20'h00308, 8'hD0);
        probe("R6 page write", 20'hD0123, 0, 1, 0, 12'h123);
        probe("R2 io with mem on", 20'h00304, 1, 0, 0, 12'h004);
        host_write(20'h0030A, 8'h11);
        probe("R9 other offset", 20'hD0123, 0, 1, 0, 12'h123);
        host_write(20'hD0008, 8'h22);
        probe("R9 write outside io", 20'hD0123, 0, 1, 0, 12'h123);
        probe("R9 no page 22", 20'h22123, 0, 0, 0, 12'h000);
        host_write(20'h00309, 8'h00);
        probe("R6 disable", 20'hD0123, 0, 0, 0, 12'h000);
    endtask

    task automatic t_conflict();
        do_reset();
        send_word(2'd0, 16'hD000);
        send_word(2'd1, 16'h00D0);
        send_word(2'd2, 16'h0001);
        send_end(1'b1);
        probe("R7 overlap", 20'hD0005, 1, 0, 1, 12'h005);
        probe("R7 mem only", 20'hD0105, 0, 1, 0, 12'h105);
    endtask

    initial begin
        t_reset_defaults();
        t_cfg_good();
        t_late_cfg();
        t_cfg_bad();
        t_sw_write();
        t_conflict();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule